// File: doc/BRIEF.md
# Recursive Split Carry-Lookahead Adder

This block adds two unsigned vectors of a parameterised width and returns the sum with the same width. It is meant as the final carry-propagate stage behind a carry-save reduction, such as the one in a parallel multiplier. In that role the incoming carry is always zero and any carry out of the top bit is dropped. The result therefore wraps modulo 2^WIDTH.

Each bit position first produces a generate flag and a propagate flag. A recursive tree then computes the incoming carry for every bit. The tree divides any span of bits into a lower part, which holds the larger half when the count is odd, and an upper part. The lower part takes the span's carry. The upper part takes a carry formed from the lower part's group flags. Group flags of the two parts are merged on the way back up. A final layer forms each sum bit as propagate XOR carry.

The block is purely combinational. It has no clock, no storage and no handshake, so its output follows its inputs in the same time step.

Top module: `cla_prefix_adder`

## Requirements
- R1: For every pair of inputs, `sum` equals (`a` + `b`) mod 2^WIDTH.
- R2: The carry out of the top bit is dropped: all-ones plus one gives zero, and any sum that overflows wraps.
- R3: The adder's own carry-in is zero: with `a` zero, `sum` equals `b`, and zero plus zero gives zero.
- R4: A carry made at bit 0 travels through a run of propagating bits all the way to the top bit. For example, a value whose top bit is 0 and all other bits are 1, plus one, gives a value with only the top bit set.
- R5: No carry arises where `a` and `b` share no set bit: `sum` then equals `a` OR `b`, and `a` with its bitwise complement gives all ones.
- R6: A carry crosses the split point at bit ceil(WIDTH/2). With the low ceil(WIDTH/2) bits of `a` set and `b` equal to 1, `sum` has only bit ceil(WIDTH/2) set.
- R7: With `a` equal to `b`, `sum` equals `a` shifted left by one, with the top bit dropped.
- R8: The output holds no state. A change of input shows on `sum` in the same time step, with no clock edge in between.
- R9: The same code is correct for every WIDTH of at least 2, odd widths included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| sum | output | WIDTH | Sum modulo 2^WIDTH |

## Verification
The bench builds four copies of the adder, with WIDTH set to 16, 5, 2 and 33. The 2-bit and 5-bit copies are small enough to run through every input pair. This covers a tree with a single split and a tree with uneven splits at every level. The 16-bit and 33-bit copies take seeded random pairs and directed patterns that aim a carry across each split boundary and the dropped top carry. The 33-bit copy also exceeds 32 bits, so the recursion has to handle a deep, uneven tree.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Combine the flags of a lower group and an upper group into one group.
  function automatic logic grp_gen(input logic g_lo, input logic p_hi, input logic g_hi);
    return g_hi | (g_lo & p_hi);
  endfunction

  function automatic logic grp_prop(input logic p_lo, input logic p_hi);
    return p_lo & p_hi;
  endfunction

  // Carry leaving a group, given the carry entering it.
  function automatic logic grp_carry(input logic g, input logic p, input logic cin);
    return g | (p & cin);
  endfunction

endpackage

// File: rtl/cla_bitgen.sv
module cla_bitgen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  output logic [WIDTH-1:0] bit_g,
  output logic [WIDTH-1:0] bit_p
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bit_g[i] = op_x[i] & op_y[i];
    assign bit_p[i] = op_x[i] ^ op_y[i];
  end
endmodule

// File: rtl/cla_span.sv
module cla_span
  import cla_pkg::*;
#(
  parameter int SPAN = 16
) (
  input  logic [SPAN-1:0] bit_g,
  input  logic [SPAN-1:0] bit_p,
  input  logic            cin,
  output logic [SPAN-1:0] carry,
  output logic            grp_g,
  output logic            grp_p
);
  localparam int LO_W = (SPAN + 1) / 2;
  localparam int HI_W = SPAN - LO_W;

  if (SPAN == 1) begin : g_leaf
    assign carry[0] = cin;
    assign grp_g    = bit_g[0];
    assign grp_p    = bit_p[0];
  end else begin : g_split
    logic lo_g, lo_p, hi_g, hi_p, hi_cin;

    cla_span #(.SPAN(LO_W)) u_lo (
      .bit_g (bit_g[LO_W-1:0]),
      .bit_p (bit_p[LO_W-1:0]),
      .cin   (cin),
      .carry (carry[LO_W-1:0]),
      .grp_g (lo_g),
      .grp_p (lo_p)
    );

    assign hi_cin = grp_carry(lo_g, lo_p, cin);

    cla_span #(.SPAN(HI_W)) u_hi (
      .bit_g (bit_g[SPAN-1:LO_W]),
      .bit_p (bit_p[SPAN-1:LO_W]),
      .cin   (hi_cin),
      .carry (carry[SPAN-1:LO_W]),
      .grp_g (hi_g),
      .grp_p (hi_p)
    );

    assign grp_g = grp_gen(lo_g, hi_p, hi_g);
    assign grp_p = grp_prop(lo_p, hi_p);
  end
endmodule

// File: rtl/cla_sumgen.sv
module cla_sumgen #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] bit_p,
  input  logic [WIDTH-1:0] carry,
  output logic [WIDTH-1:0] total
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign total[i] = bit_p[i] ^ carry[i];
  end
endmodule

// File: rtl/cla_prefix_adder.sv
module cla_prefix_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] gen_w, prop_w, carry_w;
  logic unused_top_g, unused_top_p;

  cla_bitgen #(.WIDTH(WIDTH)) u_bits (
    .op_x  (a),
    .op_y  (b),
    .bit_g (gen_w),
    .bit_p (prop_w)
  );

  cla_span #(.SPAN(WIDTH)) u_tree (
    .bit_g (gen_w),
    .bit_p (prop_w),
    .cin   (1'b0),
    .carry (carry_w),
    .grp_g (unused_top_g),
    .grp_p (unused_top_p)
  );

  cla_sumgen #(.WIDTH(WIDTH)) u_sum (
    .bit_p (prop_w),
    .carry (carry_w),
    .total (sum)
  );
endmodule

// File: rtl/cla_prefix_adder_chk.sv
module cla_prefix_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] ref_sum;
  assign ref_sum = a + b;

  always_comb begin
    // R1
    sum_mod_chk: assert (sum == ref_sum);
    if (a == '0) begin
      // R3
      zero_cin_chk: assert (sum == b);
    end
    if ((a & b) == '0) begin
      // R5
      no_carry_chk: assert (sum == (a | b));
    end
    if (a == b) begin
      // R7
      double_chk: assert (sum == {a[WIDTH-2:0], 1'b0});
    end
    if ((&a) && (b == WIDTH'(1))) begin
      // R2
      wrap_chk: assert (sum == '0);
    end
  end
endmodule

bind cla_prefix_adder cla_prefix_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a   (a),
  .b   (b),
  .sum (sum)
);

// File: tb/sim_cla_prefix_adder.sv
module sim_cla_prefix_adder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic [15:0] a0, b0, s0;
  logic [4:0]  a1, b1, s1;
  logic [1:0]  a2, b2, s2;
  logic [32:0] a3, b3, s3;

  cla_prefix_adder #(.WIDTH(16)) u0 (.a(a0), .b(b0), .sum(s0));
  cla_prefix_adder #(.WIDTH(5))  u1 (.a(a1), .b(b1), .sum(s1));
  cla_prefix_adder #(.WIDTH(2))  u2 (.a(a2), .b(b2), .sum(s2));
  cla_prefix_adder #(.WIDTH(33)) u3 (.a(a3), .b(b3), .sum(s3));

  function automatic logic [63:0] exp_add(input logic [63:0] x, input logic [63:0] y, input int w);
    logic [63:0] mask;
    mask = (64'd1 << w) - 64'd1;
    return (x + y) & mask;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // drive between edges, sample a quarter period later
  task automatic drive16(input logic [15:0] x, input logic [15:0] y, input string req);
    @(negedge clk); a0 = x; b0 = y;
    #(CLK_PERIOD/4);
    check(req, 64'(s0), exp_add(64'(x), 64'(y), 16));
  endtask

  task automatic drive33(input logic [32:0] x, input logic [32:0] y, input string req);
    @(negedge clk); a3 = x; b3 = y;
    #(CLK_PERIOD/4);
    check(req, 64'(s3), exp_add(64'(x), 64'(y), 33));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R8 watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c1a0));
    a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0; a3 = '0; b3 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // R3: zero inputs give zero
    check("R3 zero", 64'(s0), 64'd0);
    check("R3 zero w33", 64'(s3), 64'd0);

    // R3: a zero passes b through
    drive16(16'h0000, 16'hbeef, "R3 pass");
    // R2: wrap of all ones plus one
    drive16(16'hffff, 16'h0001, "R2 wrap");
    check("R2 wrap zero", 64'(s0), 64'd0);
    drive16(16'hf000, 16'h3000, "R2 overflow");
    // R4: carry rides from bit 0 to the top bit
    drive16(16'h7fff, 16'h0001, "R4 long carry");
    check("R4 top bit", 64'(s0), 64'h8000);
    // R5: disjoint bits, complement pair
    drive16(16'ha5a5, 16'h5a5a, "R5 complement");
    check("R5 all ones", 64'(s0), 64'hffff);
    // R6: carry crosses the split at bit 8
    drive16(16'h00ff, 16'h0001, "R6 split");
    check("R6 split bit", 64'(s0), 64'h0100);
    // R7: doubling
    drive16(16'hc3a1, 16'hc3a1, "R7 double");
    check("R7 shifted", 64'(s0), 64'h8742);

    // R8: input change shows with no clock edge in between
    @(posedge clk); #1;
    a0 = 16'h1234; b0 = 16'h1111;
    #1;
    check("R8 same step", 64'(s0), 64'h2345);
    a0 = 16'h0001;
    #1;
    check("R8 follow", 64'(s0), 64'h1112);

    // R1: random pairs at width 16
    for (int i = 0; i < 1500; i++)
      drive16(16'($urandom), 16'($urandom), "R1 rand16");

    // R9: every pair at width 5 and width 2
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        @(negedge clk); a1 = 5'(i); b1 = 5'(j);
        #(CLK_PERIOD/4);
        check("R9 w5", 64'(s1), exp_add(64'(i), 64'(j), 5));
      end
    end
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        @(negedge clk); a2 = 2'(i); b2 = 2'(j);
        #(CLK_PERIOD/4);
        check("R9 w2", 64'(s2), exp_add(64'(i), 64'(j), 2));
      end
    end
    // R6 at width 5: split at bit 3
    @(negedge clk); a1 = 5'd7; b1 = 5'd1;
    #(CLK_PERIOD/4);
    check("R6 w5 split", 64'(s1), 64'd8);

    // R9 / R2 / R6 at width 33
    drive33({33{1'b1}}, 33'd1, "R2 w33 wrap");
    check("R2 w33 zero", 64'(s3), 64'd0);
    drive33(33'h1ffff, 33'd1, "R6 w33 split");
    check("R6 w33 bit17", 64'(s3), 64'h20000);
    drive33(33'h0ffff_ffff, 33'd1, "R4 w33 long carry");
    for (int i = 0; i < 1500; i++)
      drive33({1'($urandom), $urandom}, {1'($urandom), $urandom}, "R9 rand33");

    summary();
    $finish;
  end
endmodule